// File: doc/BRIEF.md
# Flash Rewrite Control Register Pair

This block holds two 8-bit control and status registers for an on-chip flash rewrite controller. They sit on a simple synchronous register bus: an address, a write enable, write data, and combinational read data. The registers hold the rewrite-mode enables, the block write-protect releases, the stop/low-power control, the data-block wait selection, and the busy and error status. The flash array, the command decoder and the program/erase sequencer are outside the block. They appear only as a busy level and as error-set and clear-status strobes.

Protected enable bits can be set only by an uninterrupted pair of writes: first 0, then 1. Any other bus write, or an interrupt/DMA acknowledge pulse, between the two writes cancels the pair. The bits also depend on one another. Clearing the rewrite-mode enable forces the erase-write mode select low, and the low-block release is accepted only in rewrite mode. The stop bit reaches the array only in rewrite mode. It cannot be cleared before a minimum hold time, and clearing it starts a recovery window during which array access is still held off.

Top module: `fcr_unlock_regs`

## Requirements
- R1: After reset, register 0 (address ADDR_R0) reads 0x01 and register 1 (address ADDR_R1) reads 0x00. Register 0 bit 0 reads 1 when busy_in is 0 and 0 while busy_in is 1.
- R2: Register 0 bit 1 (rewrite-mode enable) goes to 1 only when a write of 1 to that bit follows directly a write of 0 to that bit in register 0. Any other write, or an intr_ack pulse in between, leaves the bit at 0. A write of 0 clears the bit.
- R3: Register 0 bit 2 (low-block release) needs the same 0-then-1 pair. The pair is accepted only while register 0 bit 1 is 1.
- R4: Register 1 bit 1 (erase-write mode select) needs a 0-then-1 pair while register 0 bit 1 is 1. It is forced to 0 on the cycle after register 0 bit 1 reads 0.
- R5: Register 1 bit 6 (blocks 0-3 release) is set only by a 0-then-1 pair to that bit.
- R6: Register 1 bit 7 is a plain read/write wait bit. acc_wait is glb_wait OR (acc_blk_ab AND that bit).
- R7: Register 0 bits 5:4 and register 1 bits 5:2 and 0 always read 0, whatever is written to them.
- R8: prog_err_set sets register 0 bit 6 and erase_err_set sets register 0 bit 7. Both bits stay set until a clr_status strobe clears them. A set strobe in the same cycle wins over clr_status.
- R9: Register 0 bit 3 (stop) is written directly. flash_stop is 1 only while the stop bit and register 0 bit 1 are both 1, and access_deny and a low array_ready follow it.
- R10: A write clearing the stop bit is ignored until the bit has been set for STOP_MIN_CYC cycles.
- R11: After the stop bit clears, access_deny stays 1 and array_ready stays 0 for RECOV_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| intr_ack | input | 1 | Interrupt/DMA acknowledge pulse; cancels an arming pair |
| busy_in | input | 1 | Array busy programming or erasing |
| prog_err_set | input | 1 | Program error strobe |
| erase_err_set | input | 1 | Erase error strobe |
| clr_status | input | 1 | Clear-status command strobe |
| acc_blk_ab | input | 1 | Current access targets data blocks A/B |
| glb_wait | input | 1 | Global wait-state setting |
| flash_stop | output | 1 | Stop/low-power and array reset request |
| access_deny | output | 1 | Array access held off (stop or recovery) |
| array_ready | output | 1 | Array accessible and not busy |
| acc_wait | output | 1 | Insert one wait state on the current access |

## Verification
A wrong arming flag shows up on the very next read of a protected bit. The bit sets without a proper pair, or fails to set after one, so each pair is read back in the cycle after its second write. A broken cross-bit dependency appears one cycle after the rewrite enable drops, as a mode bit that still reads 1. A faulty stop counter shows as a clear that takes effect too early, or as access_deny dropping before the recovery count ends. Both are sampled just after the clear write and again around the window's end.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
   localparam int unsigned R0_RDY    = 0;
   localparam int unsigned R0_RWEN   = 1;
   localparam int unsigned R0_LOWBLK = 2;
   localparam int unsigned R0_STOP   = 3;
   localparam int unsigned R0_PERR   = 6;
   localparam int unsigned R0_EERR   = 7;
   localparam int unsigned R1_EWMODE = 1;
   localparam int unsigned R1_BLK03  = 6;
   localparam int unsigned R1_ABWAIT = 7;

   typedef enum logic [1:0] {
      P_RWEN   = 2'd0,
      P_LOWBLK = 2'd1,
      P_EWMODE = 2'd2,
      P_BLK03  = 2'd3
   } prot_idx_e;

   localparam int unsigned NPROT = 4;
endpackage

// File: rtl/fcr_arm_bit.sv
module fcr_arm_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_any,
   input  logic wr_hit,
   input  logic bit_val,
   input  logic intr,
   input  logic allow,
   input  logic force_clr,
   output logic q
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (intr) begin
         armed <= 1'b0;
      end else if (wr_any) begin
         armed <= wr_hit & ~bit_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (force_clr) begin
         q <= 1'b0;
      end else if (wr_hit && !bit_val) begin
         q <= 1'b0;
      end else if (wr_hit && bit_val && armed && allow && !intr) begin
         q <= 1'b1;
      end
   end

   // R2: a protected bit only rises after an armed write pair
   assert_set_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(armed && wr_hit && bit_val && !intr));
endmodule

// File: rtl/fcr_stop_ctl.sv
module fcr_stop_ctl #(
   parameter int unsigned STOP_MIN_CYC = 20,
   parameter int unsigned RECOV_CYC    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wr_bit,
   output logic stop_q,
   output logic recov
);
   localparam int unsigned SW = $clog2(STOP_MIN_CYC + 1);
   localparam int unsigned RW = $clog2(RECOV_CYC + 1);

   generate
      if (STOP_MIN_CYC < 1) begin : g_bad_min
         $error("STOP_MIN_CYC must be at least 1");
      end
      if (RECOV_CYC < 1) begin : g_bad_rec
         $error("RECOV_CYC must be at least 1");
      end
   endgenerate

   logic [SW-1:0] hold_cnt;
   logic [RW-1:0] rec_cnt;
   logic          held_ok;
   logic          clr_ok;

   assign held_ok = (hold_cnt == SW'(STOP_MIN_CYC));
   assign clr_ok  = wr_hit & ~wr_bit & stop_q & held_ok;
   assign recov   = (rec_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
      end else if (wr_hit && wr_bit) begin
         stop_q <= 1'b1;
      end else if (clr_ok) begin
         stop_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
      end else if (!stop_q) begin
         hold_cnt <= '0;
      end else if (!held_ok) begin
         hold_cnt <= hold_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_cnt <= '0;
      end else if (clr_ok) begin
         rec_cnt <= RW'(RECOV_CYC);
      end else if (recov) begin
         rec_cnt <= rec_cnt - 1'b1;
      end
   end

   // R10: stop never clears before the hold counter completes
   assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_q) |-> $past(held_ok));
   // R11: recovery window is open as soon as stop drops
   assert_recov_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_q) |-> recov);
endmodule

// File: rtl/fcr_unlock_regs.sv
module fcr_unlock_regs
   import fcr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned ADDR_R0      = 0,
   parameter int unsigned ADDR_R1      = 1,
   parameter int unsigned STOP_MIN_CYC = 20,
   parameter int unsigned RECOV_CYC    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              intr_ack,
   input  logic              busy_in,
   input  logic              prog_err_set,
   input  logic              erase_err_set,
   input  logic              clr_status,
   input  logic              acc_blk_ab,
   input  logic              glb_wait,
   output logic              flash_stop,
   output logic              access_deny,
   output logic              array_ready,
   output logic              acc_wait
);
   generate
      if (ADDR_R0 == ADDR_R1) begin : g_bad_addr
         $error("register addresses must differ");
      end
      if (ADDR_R0 >= (1 << ADDR_W) || ADDR_R1 >= (1 << ADDR_W)) begin : g_bad_aw
         $error("register address does not fit ADDR_W");
      end
   endgenerate

   logic hit0, hit1;
   logic [NPROT-1:0] p_hit, p_val, p_allow, p_fclr, p_q;
   logic rw_en, lowblk, ewmode, blk03;
   logic ab_wait, prog_err, erase_err;
   logic stop_q, recov, stop_eff;
   logic [7:0] r0, r1;

   assign hit0 = bus_we && (bus_addr == ADDR_W'(ADDR_R0));
   assign hit1 = bus_we && (bus_addr == ADDR_W'(ADDR_R1));

   assign rw_en  = p_q[P_RWEN];
   assign lowblk = p_q[P_LOWBLK];
   assign ewmode = p_q[P_EWMODE];
   assign blk03  = p_q[P_BLK03];

   always_comb begin
      p_hit[P_RWEN]     = hit0;
      p_val[P_RWEN]     = bus_wdata[R0_RWEN];
      p_allow[P_RWEN]   = 1'b1;
      p_fclr[P_RWEN]    = 1'b0;
      p_hit[P_LOWBLK]   = hit0;
      p_val[P_LOWBLK]   = bus_wdata[R0_LOWBLK];
      p_allow[P_LOWBLK] = rw_en;
      p_fclr[P_LOWBLK]  = 1'b0;
      p_hit[P_EWMODE]   = hit1;
      p_val[P_EWMODE]   = bus_wdata[R1_EWMODE];
      p_allow[P_EWMODE] = rw_en;
      p_fclr[P_EWMODE]  = ~rw_en;
      p_hit[P_BLK03]    = hit1;
      p_val[P_BLK03]    = bus_wdata[R1_BLK03];
      p_allow[P_BLK03]  = 1'b1;
      p_fclr[P_BLK03]   = 1'b0;
   end

   for (genvar i = 0; i < NPROT; i++) begin : g_prot
      fcr_arm_bit u_arm (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_any   (bus_we),
         .wr_hit   (p_hit[i]),
         .bit_val  (p_val[i]),
         .intr     (intr_ack),
         .allow    (p_allow[i]),
         .force_clr(p_fclr[i]),
         .q        (p_q[i])
      );
   end

   fcr_stop_ctl #(
      .STOP_MIN_CYC(STOP_MIN_CYC),
      .RECOV_CYC   (RECOV_CYC)
   ) u_stop (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(hit0),
      .wr_bit(bus_wdata[R0_STOP]),
      .stop_q(stop_q),
      .recov (recov)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_wait <= 1'b0;
      end else if (hit1) begin
         ab_wait <= bus_wdata[R1_ABWAIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_err  <= 1'b0;
         erase_err <= 1'b0;
      end else begin
         if (prog_err_set)    prog_err  <= 1'b1;
         else if (clr_status) prog_err  <= 1'b0;
         if (erase_err_set)   erase_err <= 1'b1;
         else if (clr_status) erase_err <= 1'b0;
      end
   end

   assign stop_eff    = stop_q & rw_en;
   assign flash_stop  = stop_eff;
   assign access_deny = stop_eff | recov;
   assign array_ready = ~access_deny & ~busy_in;
   assign acc_wait    = glb_wait | (acc_blk_ab & ab_wait);

   always_comb begin
      r0 = '0;
      r0[R0_RDY]    = ~busy_in;
      r0[R0_RWEN]   = rw_en;
      r0[R0_LOWBLK] = lowblk;
      r0[R0_STOP]   = stop_q;
      r0[R0_PERR]   = prog_err;
      r0[R0_EERR]   = erase_err;
      r1 = '0;
      r1[R1_EWMODE] = ewmode;
      r1[R1_BLK03]  = blk03;
      r1[R1_ABWAIT] = ab_wait;
   end

   assign bus_rdata = (bus_addr == ADDR_W'(ADDR_R0)) ? r0 :
                      (bus_addr == ADDR_W'(ADDR_R1)) ? r1 : 8'h00;

   // R4: mode select cannot survive a cleared rewrite enable
   assert_ew_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_en |=> !ewmode);
   // R3: low-block release only rises in rewrite mode
   assert_lowblk_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lowblk) |-> $past(rw_en));
   // R8: clear-status without a new error leaves the program flag clear
   assert_err_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_status && !prog_err_set) |=> !prog_err);
   // R9: stop request implies denied access
   assert_stop_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flash_stop |-> (access_deny && !array_ready));
endmodule

// File: tb/tb_fcr_unlock_regs.sv
module tb_fcr_unlock_regs;
   localparam int CLK_PER = 10;
   localparam int STOP_MIN = 20;
   localparam int RECOV = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic intr_ack = 0, busy_in = 0, prog_err_set = 0, erase_err_set = 0;
   logic clr_status = 0, acc_blk_ab = 0, glb_wait = 0;
   logic flash_stop, access_deny, array_ready, acc_wait;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      int    kind;
      logic [7:0] exp;
      string tag;
   } item_t;
   item_t sbq[$];

   always #(CLK_PER/2) clk = ~clk;

   fcr_unlock_regs #(.STOP_MIN_CYC(STOP_MIN), .RECOV_CYC(RECOV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intr_ack(intr_ack),
      .busy_in(busy_in), .prog_err_set(prog_err_set), .erase_err_set(erase_err_set),
      .clr_status(clr_status), .acc_blk_ab(acc_blk_ab), .glb_wait(glb_wait),
      .flash_stop(flash_stop), .access_deny(access_deny),
      .array_ready(array_ready), .acc_wait(acc_wait)
   );

   // monitor: pops expected items and compares just after each falling edge
   always @(negedge clk) begin
      #1;
      while (sbq.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sbq.pop_front();
         act = (it.kind == 2) ? {4'b0, array_ready, access_deny, flash_stop, acc_wait}
                              : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [7:0] e, input string tag);
      @(negedge clk);
      bus_addr = 4'(a);
      sbq.push_back('{kind: a, exp: e, tag: tag});
   endtask

   // outputs packed as {ready, deny, stop, wait}
   task automatic outs(input logic [3:0] e, input string tag);
      @(negedge clk);
      sbq.push_back('{kind: 2, exp: {4'b0, e}, tag: tag});
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(0, 8'h01, "R1 reset reg0");
      rd(1, 8'h00, "R1 reset reg1");
      outs(4'b1000, "R1 reset outputs");
      @(negedge clk); busy_in = 1'b1;
      rd(0, 8'h00, "R1 busy flag");
      outs(4'b0000, "R1 busy not ready");
      @(negedge clk); busy_in = 1'b0;

      wr(0, 8'h02);
      rd(0, 8'h01, "R2 lone write of 1");
      wr(0, 8'h00); wr(1, 8'h00); wr(0, 8'h02);
      rd(0, 8'h01, "R2 pair broken by other write");
      wr(0, 8'h00); pulse(intr_ack); wr(0, 8'h02);
      rd(0, 8'h01, "R2 pair broken by intr_ack");
      wr(0, 8'h00); wr(0, 8'h02);
      rd(0, 8'h03, "R2 clean pair sets");

      wr(0, 8'h02); wr(0, 8'h06);
      rd(0, 8'h07, "R3 lowblk pair in rewrite mode");
      wr(0, 8'h00); wr(0, 8'h04);
      rd(0, 8'h01, "R3 lowblk refused outside rewrite mode");

      wr(1, 8'h00); wr(1, 8'h02);
      rd(1, 8'h00, "R4 mode pair refused without rewrite");
      wr(0, 8'h00); wr(0, 8'h02);
      wr(1, 8'h00); wr(1, 8'h02);
      rd(1, 8'h02, "R4 mode pair in rewrite mode");
      wr(0, 8'h00);
      rd(1, 8'h00, "R4 mode forced low");

      wr(1, 8'h40);
      rd(1, 8'h00, "R5 lone write of 1");
      wr(1, 8'h00); wr(1, 8'h40);
      rd(1, 8'h40, "R5 blk03 pair");

      wr(1, 8'h80);
      rd(1, 8'h80, "R6 wait bit readback");
      @(negedge clk); acc_blk_ab = 1; glb_wait = 0;
      outs(4'b1001, "R6 A/B access waits");
      @(negedge clk); acc_blk_ab = 0;
      outs(4'b1000, "R6 other access no wait");
      @(negedge clk); glb_wait = 1;
      outs(4'b1001, "R6 global wait");
      @(negedge clk); glb_wait = 0;
      wr(1, 8'h00);
      @(negedge clk); acc_blk_ab = 1;
      outs(4'b1000, "R6 A/B without wait bit");
      @(negedge clk); acc_blk_ab = 0;

      wr(0, 8'hF0);
      rd(0, 8'h01, "R7 reg0 reserved bits");
      wr(1, 8'h3D);
      rd(1, 8'h00, "R7 reg1 reserved bits");

      pulse(prog_err_set);
      rd(0, 8'h41, "R8 program error");
      pulse(erase_err_set);
      rd(0, 8'hC1, "R8 erase error sticky");
      pulse(clr_status);
      rd(0, 8'h01, "R8 clear status");
      @(negedge clk); prog_err_set = 1; clr_status = 1;
      @(negedge clk); prog_err_set = 0; clr_status = 0;
      rd(0, 8'h41, "R8 set beats clear");
      pulse(clr_status);

      wr(0, 8'h08);
      rd(0, 8'h09, "R9 stop bit stored outside rewrite mode");
      outs(4'b1000, "R9 stop inert outside rewrite mode");
      repeat (STOP_MIN + 4) @(negedge clk);
      wr(0, 8'h00);
      repeat (RECOV + 3) @(negedge clk);
      rd(0, 8'h01, "R10 stop cleared after hold");

      wr(0, 8'h00); wr(0, 8'h02);
      wr(0, 8'h0A);
      outs(4'b0110, "R9 stop active");
      wr(0, 8'h02);
      rd(0, 8'h0B, "R10 early clear ignored");
      repeat (STOP_MIN + 4) @(negedge clk);
      wr(0, 8'h02);
      rd(0, 8'h03, "R10 late clear accepted");
      outs(4'b0100, "R11 recovery holds access");
      repeat (RECOV + 2) @(negedge clk);
      outs(4'b1000, "R11 recovery over");

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule